// File: doc/BRIEF.md
# Socket Channel Interrupt Controller

This block gathers completion and error pulses from four network socket channels and turns them into host-visible interrupt state. Each channel owns an 8-bit status register whose bits record which kinds of event have happened since the host last looked: socket initialised, connection set up, connection ended, timeout, send done and receive done. Any status event on a channel also raises that channel's pending flag in a shared summary register. A separate per-channel data-transfer pulse raises a second flag in the same register. The single interrupt line is high while any summary flag is set.

The host talks to the block over a simple register bus with an address, a read strobe, a write strobe and 8-bit data. Read data is presented combinationally in the cycle of the read strobe. A read of a channel status register returns its value, and the register is emptied at the end of that cycle. The summary register is cleared one bit at a time by writing ones. The host therefore reads the summary to find the busy channels. It then reads each of those channels' status registers and finally writes the handled summary bits back to acknowledge them.

Top module: `sock_irq_ctrl`

## Requirements
- R1: After reset, every channel status register and the summary register read 0x00, and `irq` is low.
- R2: Channel status bit positions are: bit 1 socket initialised, bit 2 connection established, bit 3 connection closed, bit 4 timeout, bit 5 send done, bit 6 receive done. A pulse on an event input sets its bit at the next clock edge. Bits 0 and 7 always read 0. Channel n's status register sits at address 0x04+n.
- R3: Event bits in a channel status register accumulate (bitwise OR) until that register is read.
- R4: A read of a channel status register returns its current contents, and the register holds 0x00 from the following cycle onward.
- R5: If an event pulse coincides with a read of its channel's register, the read returns the value held before that event, and the new event bit remains set afterwards.
- R6: The summary register is at address 0x08. Bit n (n = 0..3) sets on the same edge as any status event of channel n. Bit 4+n sets on a data-transfer pulse of channel n.
- R7: Writing the summary register clears each bit written as 1 and leaves each bit written as 0 unchanged. A set arriving in the same cycle as a clear of the same bit wins.
- R8: `irq` is high exactly while any summary bit is set. It goes low in the cycle after the write that clears the last set bit.
- R9: Reading a channel status register does not alter the summary register, and reading the summary register alters nothing.
- R10: Reads of unmapped addresses return 0x00. Writes to status registers or to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 8 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| ev_init | input | 4 | Per-channel socket-initialised pulse |
| ev_estab | input | 4 | Per-channel connection-established pulse |
| ev_close | input | 4 | Per-channel connection-closed pulse |
| ev_tmo | input | 4 | Per-channel timeout pulse |
| ev_sent | input | 4 | Per-channel send-done pulse |
| ev_recv | input | 4 | Per-channel receive-done pulse |
| xfer | input | 4 | Per-channel data-transfer pulse |
| irq | output | 1 | Active-high interrupt request |

## Verification
Read data has no register stage, so the bench samples `rdata` one time unit after it drives the strobe, before the clock edge that would clear a status register. Event pulses, status clears and summary writes take effect on the next rising edge. `irq` follows the summary register combinationally, so the bench samples `irq` one time unit after that edge and expects the new level there. After reset is released, the internal synchronizer holds the block in reset for two more edges, and the bench waits several cycles before the first access. Coincident cases (read with event, clear with set) are driven within one cycle, so the winning value is checked on the very next access.

// File: rtl/sock_irq_pkg.sv
package sock_irq_pkg;
  // Number of event kinds latched per channel.
  localparam int NUM_EV = 6;
  // Status bit of the lowest event kind; bit 0 and the top bit stay zero.
  localparam int EV_LSB = 1;
  // Event index order inside the per-channel event vector.
  localparam int EVI_INIT  = 0;
  localparam int EVI_ESTAB = 1;
  localparam int EVI_CLOSE = 2;
  localparam int EVI_TMO   = 3;
  localparam int EVI_SENT  = 4;
  localparam int EVI_RECV  = 5;
endpackage

// File: rtl/sock_irq_chan.sv
module sock_irq_chan
  import sock_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic              rd_clr,
  output logic [DW-1:0]     stat,
  output logic              any_ev
);
  logic [DW-1:0] stat_q;
  logic [DW-1:0] stat_d;
  logic [DW-1:0] ev_bits;
  logic          stat_en;

  always_comb begin
    ev_bits = DW'({ev, {EV_LSB{1'b0}}});
    stat_en = rd_clr | (|ev);
    // New events win over the clear that a read requests.
    stat_d  = (rd_clr ? '0 : stat_q) | ev_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  assign stat   = stat_q;
  assign any_ev = |ev;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] == 1'b0) && (stat_q[DW-1] == 1'b0)); // R2
  AST_EV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((stat_q & $past(ev_bits)) == $past(ev_bits))); // R2
  AST_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3
  AST_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !(|ev)) |=> (stat_q == '0)); // R4
  AST_READ_EV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (|ev)) |=> (stat_q == $past(ev_bits))); // R5
endmodule

// File: rtl/sock_irq_decode.sv
module sock_irq_decode #(
  parameter int NCH       = 4,
  parameter int AW        = 8,
  parameter int STAT_BASE = 4,
  parameter int SUM_ADDR  = 8
) (
  input  logic [AW-1:0]  addr,
  input  logic           rd_en,
  input  logic           wr_en,
  output logic [NCH-1:0] rd_stat,
  output logic           rd_sum,
  output logic           wr_sum,
  output logic           hit
);
  logic [NCH-1:0] stat_hit;
  logic           sum_hit;

  for (genvar g = 0; g < NCH; g++) begin : g_stat_dec
    localparam logic [AW-1:0] CH_ADDR = AW'(STAT_BASE + g);
    assign stat_hit[g] = (addr == CH_ADDR);
    assign rd_stat[g]  = rd_en & stat_hit[g];
  end

  assign sum_hit = (addr == AW'(SUM_ADDR));
  assign rd_sum  = rd_en & sum_hit;
  assign wr_sum  = wr_en & sum_hit;
  assign hit     = sum_hit | (|stat_hit);
endmodule

// File: rtl/sock_irq_summary.sv
module sock_irq_summary #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend_set,
  input  logic [NCH-1:0] xfer_set,
  input  logic           wr_sum,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  sum
);
  logic [DW-1:0] sum_q;
  logic [DW-1:0] sum_d;
  logic [DW-1:0] set_m;
  logic [DW-1:0] clr_m;
  logic          sum_en;

  always_comb begin
    set_m  = DW'({xfer_set, pend_set});
    clr_m  = wr_sum ? wdata : '0;
    sum_en = wr_sum | (|set_m);
    // Set has priority over a write-one clear of the same bit.
    sum_d  = (sum_q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_m) |=> ((sum_q & $past(set_m)) == $past(set_m))); // R6
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sum |=> ((sum_q & $past(wdata & ~set_m)) == '0)); // R7
  AST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sum_q & $past(sum_q & ~clr_m)) == $past(sum_q & ~clr_m))); // R7
endmodule

// File: rtl/sock_irq_ctrl.sv
module sock_irq_ctrl
  import sock_irq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int STAT_BASE = 4,
  parameter int SUM_ADDR  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           rd_en,
  input  logic           wr_en,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] ev_init,
  input  logic [NCH-1:0] ev_estab,
  input  logic [NCH-1:0] ev_close,
  input  logic [NCH-1:0] ev_tmo,
  input  logic [NCH-1:0] ev_sent,
  input  logic [NCH-1:0] ev_recv,
  input  logic [NCH-1:0] xfer,
  output logic           irq
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  logic [NCH-1:0]    rd_stat;
  logic              rd_sum;
  logic              wr_sum;
  logic              hit;
  logic [NCH-1:0]    any_ev;
  logic [DW-1:0]     stat [NCH];
  logic [DW-1:0]     sum;
  logic [DW-1:0]     rmux;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  sock_irq_decode #(
    .NCH(NCH), .AW(AW), .STAT_BASE(STAT_BASE), .SUM_ADDR(SUM_ADDR)
  ) u_dec (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .rd_stat(rd_stat), .rd_sum(rd_sum), .wr_sum(wr_sum), .hit(hit)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [NUM_EV-1:0] ev_vec;
    always_comb begin
      ev_vec            = '0;
      ev_vec[EVI_INIT]  = ev_init[g];
      ev_vec[EVI_ESTAB] = ev_estab[g];
      ev_vec[EVI_CLOSE] = ev_close[g];
      ev_vec[EVI_TMO]   = ev_tmo[g];
      ev_vec[EVI_SENT]  = ev_sent[g];
      ev_vec[EVI_RECV]  = ev_recv[g];
    end
    sock_irq_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_int_n), .ev(ev_vec), .rd_clr(rd_stat[g]),
      .stat(stat[g]), .any_ev(any_ev[g])
    );
  end

  sock_irq_summary #(.NCH(NCH), .DW(DW)) u_sum (
    .clk(clk), .rst_n(rst_int_n), .pend_set(any_ev), .xfer_set(xfer),
    .wr_sum(wr_sum), .wdata(wdata), .sum(sum)
  );

  always_comb begin
    rmux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_stat[i]) rmux = rmux | stat[i];
    end
    if (rd_sum) rmux = rmux | sum;
  end

  assign rdata = rmux;
  assign irq   = |sum;

  AST_IRQ_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(irq) |-> $past(wr_en)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && !hit) |-> (rdata == '0)); // R10
  AST_STAT_READ_KEEPS_SUM: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && !wr_en) |=> ((sum & $past(sum)) == $past(sum))); // R9
endmodule

// File: tb/sock_irq_ctrl_test.sv
module sock_irq_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NV    = 31;

  logic       clk;
  logic       rst_n;
  logic [7:0] addr;
  logic       rd_en;
  logic       wr_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [3:0] ev_init, ev_estab, ev_close, ev_tmo, ev_sent, ev_recv, xfer;
  logic       irq;

  int total = 0;
  int bad   = 0;

  sock_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .ev_init(ev_init), .ev_estab(ev_estab),
    .ev_close(ev_close), .ev_tmo(ev_tmo), .ev_sent(ev_sent),
    .ev_recv(ev_recv), .xfer(xfer), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Layout: req[39:36] rd[35] wr[34] addr[33:26] wd[25:18] ch[17:16]
  // evm[15:9] (0 init,1 estab,2 close,3 tmo,4 sent,5 recv,6 xfer)
  // exp_rdata[8:1] exp_irq[0]
  function automatic logic [39:0] mk(input int rq, input bit rd, input bit wr,
                                     input logic [7:0] a, input logic [7:0] wd,
                                     input int ch, input logic [6:0] evm,
                                     input logic [7:0] erd, input bit eirq);
    return {4'(rq), rd, wr, a, wd, 2'(ch), evm, erd, eirq};
  endfunction

  localparam logic [39:0] VEC [NV] = '{
    mk(2,  0, 0, 8'h00, 8'h00, 0, 7'h01, 8'h00, 1), // R2 ch0 init
    mk(3,  0, 0, 8'h00, 8'h00, 0, 7'h08, 8'h00, 1), // R3 ch0 timeout accumulates
    mk(4,  1, 0, 8'h04, 8'h00, 0, 7'h00, 8'h12, 1), // R4 read ch0
    mk(4,  1, 0, 8'h04, 8'h00, 0, 7'h00, 8'h00, 1), // R4 emptied
    mk(6,  1, 0, 8'h08, 8'h00, 0, 7'h00, 8'h01, 1), // R6 pending ch0
    mk(7,  0, 1, 8'h08, 8'h00, 0, 7'h00, 8'h00, 1), // R7 write zero keeps
    mk(7,  1, 0, 8'h08, 8'h00, 0, 7'h00, 8'h01, 1), // R7
    mk(8,  0, 1, 8'h08, 8'h01, 0, 7'h00, 8'h00, 0), // R8 last bit cleared
    mk(8,  1, 0, 8'h08, 8'h00, 0, 7'h00, 8'h00, 0), // R8
    mk(2,  0, 0, 8'h00, 8'h00, 2, 7'h22, 8'h00, 1), // R2 ch2 estab+recv
    mk(6,  0, 0, 8'h00, 8'h00, 3, 7'h40, 8'h00, 1), // R6 ch3 transfer
    mk(4,  1, 0, 8'h07, 8'h00, 0, 7'h00, 8'h00, 1), // R4 ch3 status untouched by transfer
    mk(10, 0, 1, 8'h06, 8'hFF, 0, 7'h00, 8'h00, 1), // R10 write to status ignored
    mk(2,  1, 0, 8'h06, 8'h00, 0, 7'h00, 8'h44, 1), // R2 ch2 value
    mk(9,  1, 0, 8'h08, 8'h00, 0, 7'h00, 8'h84, 1), // R9 summary intact
    mk(10, 1, 0, 8'h3F, 8'h00, 0, 7'h00, 8'h00, 1), // R10 unmapped read
    mk(7,  0, 1, 8'h08, 8'h80, 0, 7'h00, 8'h00, 1), // R7 clear one bit
    mk(8,  0, 1, 8'h08, 8'h04, 0, 7'h00, 8'h00, 0), // R8
    mk(7,  1, 0, 8'h08, 8'h00, 0, 7'h00, 8'h00, 0), // R7
    mk(2,  0, 0, 8'h00, 8'h00, 1, 7'h14, 8'h00, 1), // R2 ch1 close+sent
    mk(2,  1, 0, 8'h05, 8'h00, 0, 7'h00, 8'h28, 1), // R2
    mk(9,  1, 0, 8'h08, 8'h00, 0, 7'h00, 8'h02, 1), // R9 summary read
    mk(9,  1, 0, 8'h08, 8'h00, 0, 7'h00, 8'h02, 1), // R9 no side effect
    mk(8,  0, 1, 8'h08, 8'h02, 0, 7'h00, 8'h00, 0), // R8
    mk(2,  0, 0, 8'h00, 8'h00, 0, 7'h10, 8'h00, 1), // R2 ch0 sent
    mk(5,  1, 0, 8'h04, 8'h00, 0, 7'h20, 8'h20, 1), // R5 read with recv
    mk(5,  1, 0, 8'h04, 8'h00, 0, 7'h00, 8'h40, 1), // R5 recv survived
    mk(6,  0, 1, 8'h08, 8'h01, 0, 7'h40, 8'h00, 1), // R6 clear pend, set xfer
    mk(7,  0, 1, 8'h08, 8'h10, 0, 7'h40, 8'h00, 1), // R7 set wins
    mk(7,  1, 0, 8'h08, 8'h00, 0, 7'h00, 8'h10, 1), // R7
    mk(8,  0, 1, 8'h08, 8'hFF, 0, 7'h00, 8'h00, 0)  // R8
  };

  task automatic idle_inputs();
    addr = '0; rd_en = 0; wr_en = 0; wdata = '0;
    ev_init = '0; ev_estab = '0; ev_close = '0; ev_tmo = '0;
    ev_sent = '0; ev_recv = '0; xfer = '0;
  endtask

  task automatic check(input int rq, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %02h expected %02h", rq, what, got, exp);
    end
  endtask

  task automatic access(input bit rd, input bit wr, input logic [7:0] a,
                        input logic [7:0] wd, input int ch, input logic [6:0] evm,
                        output logic [7:0] got_rd, output logic got_irq);
    @(negedge clk);
    idle_inputs();
    addr = a; rd_en = rd; wr_en = wr; wdata = wd;
    ev_init[ch]  = evm[0];
    ev_estab[ch] = evm[1];
    ev_close[ch] = evm[2];
    ev_tmo[ch]   = evm[3];
    ev_sent[ch]  = evm[4];
    ev_recv[ch]  = evm[5];
    xfer[ch]     = evm[6];
    #1 got_rd = rdata;
    @(posedge clk);
    #1 got_irq = irq;
    idle_inputs();
  endtask

  initial begin
    #(CLK_P * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic       q;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state of every register and the interrupt line
    for (int a = 4; a <= 8; a++) begin
      access(1, 0, 8'(a), 8'h00, 0, 7'h00, r, q);
      check(1, "reset register value", r, 8'h00);
    end
    check(1, "reset irq", {7'b0, q}, 8'h00);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      access(v[35], v[34], v[33:26], v[25:18], int'(v[17:16]), v[15:9], r, q);
      check(int'(v[39:36]), $sformatf("vec %0d rdata", i), r, v[8:1]);
      check(int'(v[39:36]), $sformatf("vec %0d irq", i), {7'b0, q}, {7'b0, v[0]});
    end

    // R6: all four channels raise pending at once
    @(negedge clk);
    ev_tmo = 4'hF;
    @(posedge clk);
    #1 idle_inputs();
    access(1, 0, 8'h08, 8'h00, 0, 7'h00, r, q);
    check(6, "all channels pending", r, 8'h0F);
    for (int c = 0; c < 4; c++) begin
      access(1, 0, 8'(4 + c), 8'h00, 0, 7'h00, r, q);
      check(2, $sformatf("ch%0d timeout bit", c), r, 8'h10);
    end
    access(0, 1, 8'h08, 8'h0F, 0, 7'h00, r, q);
    check(8, "irq low after clearing all", {7'b0, q}, 8'h00);

    // R1: reset in the middle of activity
    access(0, 0, 8'h00, 8'h00, 1, 7'h41, r, q);
    check(8, "irq before mid-run reset", {7'b0, q}, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(1, "irq during reset", {7'b0, irq}, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    access(1, 0, 8'h05, 8'h00, 0, 7'h00, r, q);
    check(1, "ch1 after mid-run reset", r, 8'h00);
    access(1, 0, 8'h08, 8'h00, 0, 7'h00, r, q);
    check(1, "summary after mid-run reset", r, 8'h00);
    check(1, "irq after mid-run reset", {7'b0, q}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule